// File: doc/BRIEF.md
# Clock Monitor Sticky Status Register

This block watches the clocks of a PCM voice interface: a bit clock, a frame sync and a lock indication from an external PLL. All of them are sampled on a free-running reference clock. The block drives an 8-bit status word. The low five bits are live flags: bit clock fast enough, frame sync present, bit-clocks-per-frame ratio legal, PLL locked, and memory clear finished. The top three bits are sticky fault flags. Each fault flag latches when its companion live flag drops.

Bit clock speed is measured by counting synchronized rising edges over a fixed window of reference cycles. The count is then compared against a minimum edge count, which is set to match the lowest allowed bit clock rate. Frame sync presence uses a timeout counter. The ratio check counts bit clock edges between consecutive frame sync edges and compares the result with a list of legal values.

Software clears a fault by writing 1 to its bit. Writing 0 does nothing, and writes to the live bits are ignored.

Top module: `clkmon_status`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, status reads 8'h00.
- R2: The status layout, from bit 7 down to bit 0, is: lock fault, frame fault, bit clock fault, memory clear done, PLL locked, ratio legal, frame sync present, bit clock valid.
- R3: Bit 3 equals the lock input delayed by two reference cycles, through a two-flop synchronizer.
- R4: Bit 4 equals the memory-clear-done input as sampled on the previous reference edge.
- R5: At the end of each window of WIN_CYC reference cycles, bit 0 becomes 1 if the window saw at least MIN_EDGES synchronized bit clock rising edges, and 0 otherwise. A count exactly equal to MIN_EDGES counts as valid.
- R6: Bit 1 becomes 1 on each synchronized frame sync rising edge. It becomes 0 once FS_TIMEOUT reference cycles pass with no such edge.
- R7: On a frame sync rising edge, bit 2 becomes 1 only if an earlier frame edge was seen within the timeout and the number of bit clock rising edges since that earlier edge equals one of the RATIO_LIST entries. An edge that coincides with the frame edge is counted. A timeout clears bit 2.
- R8: Bit 7 becomes 1 in the cycle after bit 3 falls from 1 to 0.
- R9: Bit 6 becomes 1 in the cycle after the AND of bits 2 and 1 falls from 1 to 0.
- R10: Bit 5 becomes 1 in the cycle after bit 0 falls from 1 to 0.
- R11: A write with a 1 in bit 7, 6 or 5 clears that fault bit on the next edge. A 0 in a fault bit leaves it unchanged. Written values in bits 4 to 0 have no effect.
- R12: When a fault is set and cleared on the same edge, the fault bit ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pclk_in | input | 1 | PCM bit clock, asynchronous to clk |
| fsync_in | input | 1 | PCM frame sync, asynchronous to clk |
| pll_lock_in | input | 1 | External PLL lock indication |
| sram_clr_done | input | 1 | High once the memory clear has finished |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 8 | Write data; a 1 in bits 7..5 clears that fault |
| status | output | 8 | Status word, layout as in R2 |

## Verification
The checker tests four properties on every cycle. Each fault bit rises one cycle after its live flag falls, whatever is being written (R8 to R10, R12). A fault bit only drops when a 1 is written to it (R11). The lock and memory-clear bits track their inputs with the stated latency. Which edge a fault latches on depends on the frame sync and bit clock waveforms, so the frequency threshold, the exact-boundary count, the timeout and the legal and illegal frame ratios can only be shown by the bench. It runs scenarios at several bit clock periods and frame lengths against a cycle model of the whole status word.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

    localparam int STAT_W = 8;
    localparam int N_FLT  = 3;

    // fault vector indices; the order matches status bits 5,6,7
    localparam int FI_PC  = 0;
    localparam int FI_FS  = 1;
    localparam int FI_PLL = 2;

    typedef struct packed {
        logic lock_flt;
        logic frame_flt;
        logic bclk_flt;
        logic mem_clr_done;
        logic locked;
        logic ratio_ok;
        logic frame_ok;
        logic bclk_ok;
    } stat_t;

    function automatic logic [N_FLT-1:0] clr_mask(input logic we,
                                                 input logic [STAT_W-1:0] wd);
        return we ? wd[STAT_W-1 -: N_FLT] : '0;
    endfunction

endpackage

// File: rtl/clkmon_sync.sv
module clkmon_sync #(
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] stage1;
    logic [N-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/clkmon_rate.sv
module clkmon_rate #(
    parameter int WIN_CYC   = 64,
    parameter int MIN_EDGES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic bclk_rise,
    output logic bclk_ok
);
    localparam int WW = $clog2(WIN_CYC);
    localparam int EW = $clog2(WIN_CYC + 1);
    localparam logic [WW-1:0] WIN_LAST  = WW'(WIN_CYC - 1);
    localparam logic [EW:0]   EDGE_THR  = (EW + 1)'(MIN_EDGES);

    logic [WW-1:0] win_cnt;
    logic [EW-1:0] edge_cnt;
    logic [EW:0]   edge_total;

    assign edge_total = {1'b0, edge_cnt} + (EW + 1)'(bclk_rise);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_cnt  <= '0;
            edge_cnt <= '0;
            bclk_ok  <= 1'b0;
        end else if (win_cnt == WIN_LAST) begin
            win_cnt  <= '0;
            edge_cnt <= '0;
            bclk_ok  <= (edge_total >= EDGE_THR);
        end else begin
            win_cnt  <= win_cnt + 1'b1;
            edge_cnt <= edge_total[EW-1:0];
        end
    end
endmodule

// File: rtl/clkmon_frame.sv
module clkmon_frame #(
    parameter int FS_TIMEOUT = 128,
    parameter int NUM_RATIOS = 2,
    parameter int RATIO_W    = 10,
    parameter logic [NUM_RATIOS*RATIO_W-1:0] RATIO_LIST = {10'd16, 10'd8}
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_rise,
    input  logic bclk_rise,
    output logic frame_ok,
    output logic ratio_ok
);
    localparam int TW = $clog2(FS_TIMEOUT);
    localparam logic [TW-1:0]      T_LAST  = TW'(FS_TIMEOUT - 1);
    localparam logic [RATIO_W-1:0] PER_MAX = '1;

    logic [TW-1:0]         idle_cnt;
    logic [RATIO_W-1:0]    per_cnt;
    logic [RATIO_W-1:0]    per_next;
    logic                  prior_seen;
    logic [NUM_RATIOS-1:0] ratio_hit;

    assign per_next = (per_cnt == PER_MAX) ? per_cnt
                                           : per_cnt + RATIO_W'(bclk_rise);

    for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_ratio
        assign ratio_hit[g] = (per_next == RATIO_LIST[g*RATIO_W +: RATIO_W]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_cnt   <= '0;
            per_cnt    <= '0;
            prior_seen <= 1'b0;
            frame_ok   <= 1'b0;
            ratio_ok   <= 1'b0;
        end else if (frame_rise) begin
            idle_cnt   <= '0;
            per_cnt    <= '0;
            prior_seen <= 1'b1;
            frame_ok   <= 1'b1;
            ratio_ok   <= prior_seen & (|ratio_hit);
        end else begin
            per_cnt <= per_next;
            if (idle_cnt == T_LAST) begin
                prior_seen <= 1'b0;
                frame_ok   <= 1'b0;
                ratio_ok   <= 1'b0;
            end else begin
                idle_cnt <= idle_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/clkmon_sticky.sv
module clkmon_sticky #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] live,
    input  logic [N-1:0] clr,
    output logic [N-1:0] fault
);
    logic [N-1:0] live_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                live_q[i] <= 1'b0;
                fault[i]  <= 1'b0;
            end else begin
                live_q[i] <= live[i];
                // a falling live flag outranks a simultaneous clear
                fault[i]  <= (live_q[i] & ~live[i]) | (fault[i] & ~clr[i]);
            end
        end
    end
endmodule

// File: rtl/clkmon_status.sv
module clkmon_status
    import clkmon_pkg::*;
#(
    parameter int WIN_CYC    = 64,
    parameter int MIN_EDGES  = 8,
    parameter int FS_TIMEOUT = 128,
    parameter int NUM_RATIOS = 2,
    parameter int RATIO_W    = 10,
    parameter logic [NUM_RATIOS*RATIO_W-1:0] RATIO_LIST = {10'd16, 10'd8}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pclk_in,
    input  logic              fsync_in,
    input  logic              pll_lock_in,
    input  logic              sram_clr_done,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    output logic [STAT_W-1:0] status
);
    logic [2:0]       sync_lvl;
    logic             bclk_q;
    logic             frame_q;
    logic             bclk_rise;
    logic             frame_rise;
    logic             bclk_ok;
    logic             frame_ok;
    logic             ratio_ok;
    logic             mem_done_q;
    logic [N_FLT-1:0] live;
    logic [N_FLT-1:0] fault;
    stat_t            st;

    clkmon_sync #(.N(3)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({pll_lock_in, fsync_in, pclk_in}),
        .q   (sync_lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q     <= 1'b0;
            frame_q    <= 1'b0;
            mem_done_q <= 1'b0;
        end else begin
            bclk_q     <= sync_lvl[0];
            frame_q    <= sync_lvl[1];
            mem_done_q <= sram_clr_done;
        end
    end

    assign bclk_rise  = sync_lvl[0] & ~bclk_q;
    assign frame_rise = sync_lvl[1] & ~frame_q;

    clkmon_rate #(
        .WIN_CYC   (WIN_CYC),
        .MIN_EDGES (MIN_EDGES)
    ) u_rate (
        .clk       (clk),
        .rst       (rst),
        .bclk_rise (bclk_rise),
        .bclk_ok   (bclk_ok)
    );

    clkmon_frame #(
        .FS_TIMEOUT (FS_TIMEOUT),
        .NUM_RATIOS (NUM_RATIOS),
        .RATIO_W    (RATIO_W),
        .RATIO_LIST (RATIO_LIST)
    ) u_frame (
        .clk        (clk),
        .rst        (rst),
        .frame_rise (frame_rise),
        .bclk_rise  (bclk_rise),
        .frame_ok   (frame_ok),
        .ratio_ok   (ratio_ok)
    );

    always_comb begin
        live         = '0;
        live[FI_PC]  = bclk_ok;
        live[FI_FS]  = frame_ok & ratio_ok;
        live[FI_PLL] = sync_lvl[2];
    end

    clkmon_sticky #(.N(N_FLT)) u_sticky (
        .clk   (clk),
        .rst   (rst),
        .live  (live),
        .clr   (clr_mask(wr_en, wr_data)),
        .fault (fault)
    );

    always_comb begin
        st.lock_flt     = fault[FI_PLL];
        st.frame_flt    = fault[FI_FS];
        st.bclk_flt     = fault[FI_PC];
        st.mem_clr_done = mem_done_q;
        st.locked       = sync_lvl[2];
        st.ratio_ok     = ratio_ok;
        st.frame_ok     = frame_ok;
        st.bclk_ok      = bclk_ok;
    end

    assign status = st;
endmodule

// File: rtl/clkmon_status_sva.sv
module clkmon_status_sva (
    input logic       clk,
    input logic       rst,
    input logic       pll_lock_in,
    input logic       sram_clr_done,
    input logic       wr_en,
    input logic [2:0] wr_hi,
    input logic [7:0] status
);
    logic [1:0] warm;

    always_ff @(posedge clk) begin
        if (rst)              warm <= 2'd0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (status == 8'h00));

    p_lock_latency_r3: assert property (@(posedge clk) disable iff (rst)
        (warm >= 2'd2) |-> (status[3] == $past(pll_lock_in, 2)));

    p_memclr_latency_r4: assert property (@(posedge clk) disable iff (rst)
        (warm >= 2'd1) |-> (status[4] == $past(sram_clr_done)));

    // R12: these hold whatever is written on the same edge
    p_lock_fall_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(status[3]) |=> status[7]);

    p_frame_fall_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(status[2] & status[1]) |=> status[6]);

    p_bclk_fall_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(status[0]) |=> status[5]);

    p_lock_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (!status[7] && !$fell(status[3])) |=> !status[7]);

    for (genvar i = 0; i < 3; i++) begin : g_hold
        p_fault_hold_r11: assert property (@(posedge clk) disable iff (rst)
            (status[5+i] && !(wr_en && wr_hi[i])) |=> status[5+i]);
    end
endmodule

bind clkmon_status clkmon_status_sva u_sva (
    .clk           (clk),
    .rst           (rst),
    .pll_lock_in   (pll_lock_in),
    .sram_clr_done (sram_clr_done),
    .wr_en         (wr_en),
    .wr_hi         (wr_data[7:5]),
    .status        (status)
);

// File: tb/clkmon_status_tb.sv
`timescale 1ns/1ps
module clkmon_status_tb;
    localparam int WIN  = 64;
    localparam int MINE = 8;
    localparam int TMO  = 128;
    localparam int PMAX = 1023;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pclk_in = 1'b0;
    logic       fsync_in = 1'b0;
    logic       pll_lock_in = 1'b0;
    logic       sram_clr_done = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] status;

    always #10 clk = ~clk;

    clkmon_status u_dut (
        .clk           (clk),
        .rst           (rst),
        .pclk_in       (pclk_in),
        .fsync_in      (fsync_in),
        .pll_lock_in   (pll_lock_in),
        .sram_clr_done (sram_clr_done),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .status        (status)
    );

    int vectors = 0;
    int fails   = 0;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // stimulus generator configuration
    int pclk_half = 2;
    int fs_every  = 8;
    int pc_cnt = 0;
    int fs_pc  = 0;

    // inputs as seen on the last rising edge
    bit started = 0;
    bit cp, cf, cl, cd, crst, cwe;
    bit [7:0] cwd;
    always @(posedge clk) begin
        cp = pclk_in; cf = fsync_in; cl = pll_lock_in; cd = sram_clr_done;
        crst = rst; cwe = wr_en; cwd = wr_data;
        started = 1;
    end

    // reference model state
    bit qp[$], qf[$], ql[$];
    int m_win, m_edges, m_tmr, m_per;
    bit m_pc, m_fsval, m_fsdet, m_seen, m_lk, m_sr;
    bit m_lk_q, m_pc_q, m_fs_q, m_f7, m_f6, m_f5;

    function automatic string bit_req(input int b);
        case (b)
            7: return "R8";
            6: return "R9";
            5: return "R10";
            4: return "R4";
            3: return "R3";
            2: return "R7";
            1: return "R6";
            default: return "R5";
        endcase
    endfunction

    always @(negedge clk) begin
        if (started) begin
            if (crst) begin
                qp = '{0, 0, 0}; qf = '{0, 0, 0}; ql = '{0, 0, 0};
                m_win = 0; m_edges = 0; m_tmr = 0; m_per = 0;
                {m_pc, m_fsval, m_fsdet, m_seen, m_lk, m_sr} = '0;
                {m_lk_q, m_pc_q, m_fs_q, m_f7, m_f6, m_f5} = '0;
            end else begin
                bit rp, rf, ok_fs;
                bit n_pc, n_fsval, n_fsdet, n_seen, n_f7, n_f6, n_f5;
                int n_win, n_edges, n_tmr, n_per;
                bit [7:0] clr;
                rp = qp[1] && !qp[2];
                rf = qf[1] && !qf[2];
                n_pc = m_pc; n_win = m_win + 1; n_edges = m_edges + rp;
                if (m_win == WIN - 1) begin
                    n_pc = ((m_edges + rp) >= MINE); n_win = 0; n_edges = 0;
                end
                n_per = (m_per == PMAX) ? m_per : m_per + rp;
                n_fsval = m_fsval; n_fsdet = m_fsdet; n_seen = m_seen; n_tmr = m_tmr;
                if (rf) begin
                    n_fsdet = m_seen && (n_per == 8 || n_per == 16);
                    n_tmr = 0; n_fsval = 1; n_seen = 1; n_per = 0;
                end else if (m_tmr == TMO - 1) begin
                    n_fsval = 0; n_fsdet = 0; n_seen = 0;
                end else begin
                    n_tmr = m_tmr + 1;
                end
                clr = cwe ? cwd : 8'h00;
                ok_fs = m_fsval && m_fsdet;
                n_f7 = (m_lk_q && !m_lk) || (m_f7 && !clr[7]);
                n_f6 = (m_fs_q && !ok_fs) || (m_f6 && !clr[6]);
                n_f5 = (m_pc_q && !m_pc) || (m_f5 && !clr[5]);
                m_lk_q = m_lk; m_fs_q = ok_fs; m_pc_q = m_pc;
                m_lk = ql[0]; m_sr = cd;
                m_f7 = n_f7; m_f6 = n_f6; m_f5 = n_f5;
                m_pc = n_pc; m_win = n_win; m_edges = n_edges;
                m_fsval = n_fsval; m_fsdet = n_fsdet; m_seen = n_seen;
                m_tmr = n_tmr; m_per = n_per;
                qp.push_front(cp); void'(qp.pop_back());
                qf.push_front(cf); void'(qf.pop_back());
                ql.push_front(cl); void'(ql.pop_back());
            end
            begin
                bit [7:0] exp;
                exp = {m_f7, m_f6, m_f5, m_sr, m_lk, m_fsdet, m_fsval, m_pc};
                vectors++;
                if (status !== exp) begin
                    fails++;
                    for (int b = 7; b >= 0; b--)
                        if (status[b] !== exp[b])
                            $display("FAIL %s bit %0d: actual %b expected %b",
                                     bit_req(b), b, status[b], exp[b]);
                end
            end
        end
        // bit clock and frame sync generator
        pc_cnt++;
        if (pc_cnt >= pclk_half) begin
            pc_cnt = 0;
            pclk_in = ~pclk_in;
            if (pclk_in) begin
                if (fs_every != 0) begin
                    fs_pc++;
                    if (fs_pc >= fs_every) begin
                        fs_pc = 0;
                        fsync_in = 1'b1;
                    end else begin
                        fsync_in = 1'b0;
                    end
                end else begin
                    fsync_in = 1'b0;
                end
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (10) tick();
        @(negedge clk); chk("R1 in reset", status, 8'h00);
        tick(); rst = 1'b0; pll_lock_in = 1'b1;
        tick();
        @(negedge clk); chk("R1 after release", status, 8'h00);

        repeat (400) tick();
        @(negedge clk); chk("R2 layout with healthy clocks", status, 8'h0F);

        tick(); sram_clr_done = 1'b1;
        tick();
        @(negedge clk); chk("R4 memory clear done", status, 8'h1F);

        // R12: clear written on the same edge the lock fault is set
        tick(); pll_lock_in = 1'b0;
        tick();
        tick(); wr_en = 1'b1; wr_data = 8'h80;
        tick(); wr_en = 1'b0; wr_data = 8'h00;
        @(negedge clk); chk("R12 set beats clear", status & 8'h88, 8'h80);
        repeat (3) tick();
        @(negedge clk); chk("R8 lock fault held", status[7], 1'b1);
        tick(); wr_en = 1'b1; wr_data = 8'h00;
        tick(); wr_en = 1'b0;
        @(negedge clk); chk("R11 zero write ignored", status[7], 1'b1);
        tick(); wr_en = 1'b1; wr_data = 8'h80;
        tick(); wr_en = 1'b0; wr_data = 8'h00;
        @(negedge clk); chk("R11 write one clears", status[7], 1'b0);
        pll_lock_in = 1'b1;
        repeat (5) tick();
        @(negedge clk); chk("R3 lock restored", status[3], 1'b1);

        tick(); wr_en = 1'b1; wr_data = 8'h00;
        tick(); wr_en = 1'b0;
        @(negedge clk); chk("R11 live bits unaffected", status, 8'h1F);

        fs_every = 12;
        repeat (200) tick();
        @(negedge clk); chk("R7 illegal ratio / R9 fault", status & 8'h46, 8'h42);
        fs_every = 8;
        repeat (200) tick();
        @(negedge clk); chk("R7 legal ratio / R11 sticky", status & 8'h46, 8'h46);
        tick(); wr_en = 1'b1; wr_data = 8'h40;
        tick(); wr_en = 1'b0; wr_data = 8'h00;
        @(negedge clk); chk("R11 frame fault cleared", status[6], 1'b0);

        fs_every = 0;
        repeat (300) tick();
        @(negedge clk); chk("R6 timeout / R9 fault", status & 8'h46, 8'h40);
        tick(); wr_en = 1'b1; wr_data = 8'h40;
        tick(); wr_en = 1'b0; wr_data = 8'h00;

        pclk_half = 16;
        repeat (300) tick();
        @(negedge clk); chk("R5 slow clock / R10 fault", status & 8'h61, 8'h20);
        tick(); wr_en = 1'b1; wr_data = 8'h20;
        tick(); wr_en = 1'b0; wr_data = 8'h00;
        @(negedge clk); chk("R11 bclk fault cleared", status[5], 1'b0);

        pclk_half = 4;
        repeat (300) tick();
        @(negedge clk); chk("R5 count equal to threshold", status[0], 1'b1);
        pclk_half = 5;
        repeat (300) tick();
        @(negedge clk); chk("R5 below threshold / R10", status & 8'h21, 8'h20);

        repeat (5) tick();
        finish_run();
    end
endmodule